// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of an embedded flash controller. A processor reaches it through a small byte-wide register port and through an array write port. A command is written in three steps. First, one write to the array port supplies the target word address and a data word, which is a dummy value for erase commands. Second, a write to the command register supplies the operation code. Third, a write of 1 to the buffer-empty bit of the status register launches the command. Before launch, the block checks the target against a protection window. It also checks that the divider has been loaded and that the steps came in order.

An accepted command waits in a one-deep buffer until the execution slot is free. The flash array is modelled as a busy timer. The timer counts ticks of a divided clock. Erase operations run for one parameterised tick count and word programming runs for another. The completion flag reports that both the buffer and the execution slot are empty. Two sticky error flags, one for access errors and one for protection violations, block further command writes until software clears them by writing 1.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `status` reads 0xC0 (buffer-empty bit 7 and complete bit 6 set, error bits 5 and 4 clear, bits 3..0 always zero). After reset, `div_loaded` and `op_busy` are 0.
- R2: The first write to register select 0 (divider) loads the divider value from `reg_wdata[DIV_W-1:0]` and sets `div_loaded`. Every later divider write is ignored until reset.
- R3: A sequence of an array write, a command write (select 2) with a supported code, and a status write (select 3) with bit 7 set fills the buffer. Bit 7 of `status` reads 0 in the cycle after the launch write. One cycle later the command enters execution: `op_busy` is 1, `op_cmd` and `op_addr` show the command, and bit 7 returns to 1.
- R4: Supported codes are 0x41 (mass erase), 0x40 (sector erase) and 0x20 (word program). An operation keeps `op_busy` high for N*(D+1) cycles, where D is the divider value and N is ERASE_TICKS for either erase or PROG_TICKS for program. Bit 6 is 0 while `op_busy` is high.
- R5: A command launched while another executes is held in the buffer, and bit 7 stays 0 meanwhile. Array writes, command writes and launches are ignored while the buffer is full. The held command starts on the cycle after the running one ends. Bit 6 stays 0 until both have finished.
- R6: Select 1 writes P, the number of protected sectors at the top of the array. The sector index is `arr_addr[ADDR_W-1:SECT_W]`. Program or sector erase of a sector at or above 2^(ADDR_W-SECT_W)-P, or mass erase with P nonzero, sets bit 5 and does not launch.
- R7: Bit 4 (access error) sets, and the partial sequence is discarded, in each of these cases:
  - a command write with no array write before it;
  - an unsupported command code;
  - a second array write in the same sequence;
  - a launch with no command written;
  - a launch while the divider is not loaded.
- R8: While bit 5 or bit 4 is set, array writes, command writes and launches are ignored. A status write with bit 5 set clears bit 5, and one with bit 4 set clears bit 4.
- R9: A status write of 0x00 discards a partly written sequence, so a following launch is an access error.
- R10: Bit 7 reads 1 exactly when the buffer is empty. Bit 6 reads 1 exactly when the buffer is empty and no operation is executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 divider, 1 protection, 2 command, 3 status |
| reg_wdata | input | 8 | Register write data |
| arr_wr | input | 1 | Array write strobe (address/data step) |
| arr_addr | input | ADDR_W | Target word address |
| arr_wdata | input | DATA_W | Program data or dummy value |
| status | output | 8 | Flags: 7 buffer empty, 6 complete, 5 protection error, 4 access error |
| div_loaded | output | 1 | Divider has been written |
| op_busy | output | 1 | An operation is executing |
| op_cmd | output | 8 | Code of the executing operation |
| op_addr | output | ADDR_W | Address of the executing operation |
| op_data | output | DATA_W | Data of the executing operation |

## Verification
The hardest state to reach is the short window in which one operation has just ended and the held command has not yet started. In that window `op_busy` is low and the complete flag must still read 0. The bench launches a long sector erase and completes a second full sequence while the erase runs. It then tries a third array write against the full buffer and watches the cycle in which the first operation ends. A following bare command write shows whether the ignored array write advanced the sequence.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_PROT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_CMD  = 2'd2
  } seq_st_e;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_MASS = 8'h41;
  localparam logic [CMD_W-1:0] OP_SECT = 8'h40;
  localparam logic [CMD_W-1:0] OP_PROG = 8'h20;

  localparam int BIT_EMPTY = 7;
  localparam int BIT_DONE  = 6;
  localparam int BIT_PROT  = 5;
  localparam int BIT_ACC   = 4;

  function automatic logic op_known(input logic [CMD_W-1:0] c);
    return (c == OP_MASS) || (c == OP_SECT) || (c == OP_PROG);
  endfunction

  function automatic logic op_is_prog(input logic [CMD_W-1:0] c);
    return c == OP_PROG;
  endfunction

endpackage

// File: rtl/fcs_guard.sv
module fcs_guard
  import fcs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [IDX_W-1:0] sect_i,
  input  logic [7:0]       prot_i,
  output logic             viol_o
);

  localparam int NSECT = 1 << IDX_W;
  localparam int LIM_W = IDX_W + 1;

  logic [LIM_W-1:0] sect_ext;
  logic [LIM_W-1:0] limit;

  always_comb begin
    sect_ext = {1'b0, sect_i};
    if (int'(prot_i) >= NSECT) begin
      limit = '0;
    end else begin
      limit = LIM_W'(NSECT - int'(prot_i));
    end
    if (cmd_i == OP_MASS) begin
      viol_o = |prot_i;
    end else begin
      viol_o = sect_ext >= limit;
    end
  end

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_wdata,
  input  logic              buf_full,
  input  logic              viol_i,
  output logic              push_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [7:0]        prot_o,
  output logic              pviol_o,
  output logic              accerr_o,
  output logic              div_ld_o,
  output logic [DIV_W-1:0]  div_val_o
);

  seq_st_e  st;
  reg_sel_e sel;
  logic     err;
  logic     launch_req;

  assign sel = reg_sel_e'(reg_sel);
  assign err = pviol_o | accerr_o;

  // a launch attempt that is not blocked by a sticky flag or a full buffer
  assign launch_req = reg_wr && (sel == SEL_STAT) && (reg_wdata != 8'h00) &&
                      reg_wdata[BIT_EMPTY] && !err && !buf_full;

  assign push_o = launch_req && (st == SQ_CMD) && div_ld_o && !viol_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      pviol_o   <= 1'b0;
      accerr_o  <= 1'b0;
      div_ld_o  <= 1'b0;
      div_val_o <= '0;
      prot_o    <= '0;
      cmd_o     <= '0;
      addr_o    <= '0;
      data_o    <= '0;
    end else if (reg_wr) begin
      unique case (sel)
        SEL_DIV: begin
          if (!div_ld_o) begin
            div_val_o <= reg_wdata[DIV_W-1:0];
            div_ld_o  <= 1'b1;
          end
        end
        SEL_PROT: prot_o <= reg_wdata;
        SEL_CMD: begin
          if (!err && !buf_full) begin
            if (st == SQ_ADDR && op_known(reg_wdata)) begin
              cmd_o <= reg_wdata;
              st    <= SQ_CMD;
            end else begin
              accerr_o <= 1'b1;
              st       <= SQ_IDLE;
            end
          end
        end
        SEL_STAT: begin
          if (reg_wdata[BIT_PROT]) pviol_o  <= 1'b0;
          if (reg_wdata[BIT_ACC])  accerr_o <= 1'b0;
          if (reg_wdata == 8'h00) begin
            st <= SQ_IDLE;
          end else if (launch_req) begin
            st <= SQ_IDLE;
            if (st != SQ_CMD || !div_ld_o) begin
              accerr_o <= 1'b1;
            end else if (viol_i) begin
              pviol_o <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (arr_wr && !err && !buf_full) begin
      if (st == SQ_IDLE) begin
        addr_o <= arr_addr;
        data_o <= arr_wdata;
        st     <= SQ_ADDR;
      end else begin
        accerr_o <= 1'b1;
        st       <= SQ_IDLE;
      end
    end
  end

endmodule

// File: rtl/fcs_tick.sv
module fcs_tick #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] pcnt;

  assign tick = run && (pcnt == div_val);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else if (run) begin
      if (pcnt == div_val) begin
        pcnt <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fcs_exec.sv
module fcs_exec
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int ERASE_TICKS = 6,
  parameter int PROG_TICKS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              tick,
  output logic              pend_o,
  output logic              act_o,
  output logic              start_o,
  output logic [CMD_W-1:0]  act_cmd,
  output logic [ADDR_W-1:0] act_addr,
  output logic [DATA_W-1:0] act_data
);

  localparam int MAXT  = (ERASE_TICKS > PROG_TICKS) ? ERASE_TICKS : PROG_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);

  logic [CMD_W-1:0]  p_cmd;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_data;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  load_val;

  assign start_o  = !act_o && pend_o;
  assign load_val = op_is_prog(p_cmd) ? CNT_W'(PROG_TICKS) : CNT_W'(ERASE_TICKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o   <= 1'b0;
      act_o    <= 1'b0;
      cnt      <= '0;
      p_cmd    <= '0;
      p_addr   <= '0;
      p_data   <= '0;
      act_cmd  <= '0;
      act_addr <= '0;
      act_data <= '0;
    end else begin
      if (push) begin
        pend_o <= 1'b1;
        p_cmd  <= in_cmd;
        p_addr <= in_addr;
        p_data <= in_data;
      end
      if (act_o && tick) begin
        if (cnt == CNT_W'(1)) act_o <= 1'b0;
        cnt <= cnt - 1'b1;
      end
      if (start_o) begin
        act_o    <= 1'b1;
        pend_o   <= 1'b0;
        act_cmd  <= p_cmd;
        act_addr <= p_addr;
        act_data <= p_data;
        cnt      <= load_val;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int SECT_W      = 4,
  parameter int DIV_W       = 7,
  parameter int ERASE_TICKS = 6,
  parameter int PROG_TICKS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_wdata,
  output logic [7:0]        status,
  output logic              div_loaded,
  output logic              op_busy,
  output logic [7:0]        op_cmd,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  localparam int IDX_W = ADDR_W - SECT_W;

  logic              push;
  logic              viol;
  logic [CMD_W-1:0]  seq_cmd;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_data;
  logic [7:0]        prot;
  logic              pviol;
  logic              accerr;
  logic [DIV_W-1:0]  div_val;
  logic              pend;
  logic              start;
  logic              tick;

  fcs_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .buf_full(pend), .viol_i(viol), .push_o(push),
    .cmd_o(seq_cmd), .addr_o(seq_addr), .data_o(seq_data),
    .prot_o(prot), .pviol_o(pviol), .accerr_o(accerr),
    .div_ld_o(div_loaded), .div_val_o(div_val)
  );

  fcs_guard #(
    .IDX_W(IDX_W)
  ) u_guard (
    .cmd_i(seq_cmd), .sect_i(seq_addr[ADDR_W-1:SECT_W]),
    .prot_i(prot), .viol_o(viol)
  );

  fcs_exec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ERASE_TICKS(ERASE_TICKS), .PROG_TICKS(PROG_TICKS)
  ) u_exec (
    .clk(clk), .rst(rst), .push(push),
    .in_cmd(seq_cmd), .in_addr(seq_addr), .in_data(seq_data),
    .tick(tick), .pend_o(pend), .act_o(op_busy), .start_o(start),
    .act_cmd(op_cmd), .act_addr(op_addr), .act_data(op_data)
  );

  fcs_tick #(
    .DIV_W(DIV_W)
  ) u_tick (
    .clk(clk), .rst(rst), .restart(start), .run(op_busy),
    .div_val(div_val), .tick(tick)
  );

  assign status = {~pend, ~(pend | op_busy), pviol, accerr, 4'b0000};

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       flags,   // {empty, done, prot err, access err}
  input logic             div_loaded,
  input logic             op_busy,
  input logic [7:0]       op_cmd,
  input logic [DIV_W-1:0] div_val
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags == 4'b1100 && !op_busy && !div_loaded));

  p_div_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    $past(div_loaded) |-> (div_loaded && $stable(div_val)));

  p_cmd_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (op_busy && $past(op_busy)) |-> $stable(op_cmd));

  p_done_low_busy_r4: assert property (@(posedge clk) disable iff (rst)
    op_busy |-> !flags[2]);

  p_buf_release_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(op_busy) |-> flags[3]);

  p_err_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    ((flags[1] || flags[0]) && flags[3]) |=> flags[3]);

  p_done_low_pend_r10: assert property (@(posedge clk) disable iff (rst)
    !flags[3] |-> !flags[2]);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .flags(status[7:4]), .div_loaded(div_loaded),
  .op_busy(op_busy), .op_cmd(op_cmd), .div_val(div_val)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;

  localparam int ERASE_T = 6;
  localparam int PROG_T  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic        arr_wr = 1'b0;
  logic [9:0]  arr_addr = '0;
  logic [15:0] arr_wdata = '0;
  logic [7:0]  status;
  logic        div_loaded;
  logic        op_busy;
  logic [7:0]  op_cmd;
  logic [9:0]  op_addr;
  logic [15:0] op_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(10), .DATA_W(16), .SECT_W(4), .DIV_W(7),
    .ERASE_TICKS(ERASE_T), .PROG_TICKS(PROG_T)
  ) u_flash_cmd_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .arr_wr(arr_wr), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .status(status), .div_loaded(div_loaded),
    .op_busy(op_busy), .op_cmd(op_cmd), .op_addr(op_addr), .op_data(op_data)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit         m_dl, m_pv, m_ae, m_act, m_full, m_err, m_go;
  int         m_div, m_prot, m_seq, m_rem;
  logic [7:0] m_cmd, m_acmd;
  logic [9:0] m_addr, m_aaddr;
  logic [7:0] q_cmd[$];
  logic [9:0] q_addr[$];
  logic [7:0] exp_st;

  function automatic bit m_viol(input logic [7:0] c, input logic [9:0] a, input int p);
    int sec;
    int lim;
    sec = int'(a) / 16;
    lim = (p >= 64) ? 0 : 64 - p;
    if (c == 8'h41) return p != 0;
    return sec >= lim;
  endfunction

  function automatic bit m_known(input logic [7:0] c);
    return c == 8'h41 || c == 8'h40 || c == 8'h20;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dl = 0; m_pv = 0; m_ae = 0; m_act = 0; m_div = 0; m_prot = 0;
      m_seq = 0; m_rem = 0; q_cmd.delete(); q_addr.delete();
    end else begin
      m_full = q_cmd.size() > 0;
      m_err  = m_pv || m_ae;
      m_go   = !m_act && m_full;
      if (m_act) begin
        m_rem--;
        if (m_rem == 0) m_act = 0;
      end
      if (m_go) begin
        m_act   = 1;
        m_acmd  = q_cmd.pop_front();
        m_aaddr = q_addr.pop_front();
        m_rem   = ((m_acmd == 8'h20) ? PROG_T : ERASE_T) * (m_div + 1);
      end
      if (reg_wr) begin
        case (reg_sel)
          2'd0: if (!m_dl) begin m_div = int'(reg_wdata[6:0]); m_dl = 1; end
          2'd1: m_prot = int'(reg_wdata);
          2'd2: if (!m_err && !m_full) begin
            if (m_seq == 1 && m_known(reg_wdata)) begin m_cmd = reg_wdata; m_seq = 2; end
            else begin m_ae = 1; m_seq = 0; end
          end
          default: begin
            if (reg_wdata[5]) m_pv = 0;
            if (reg_wdata[4]) m_ae = 0;
            if (reg_wdata == 8'h00) m_seq = 0;
            else if (reg_wdata[7] && !m_err && !m_full) begin
              if (m_seq != 2 || !m_dl) m_ae = 1;
              else if (m_viol(m_cmd, m_addr, m_prot)) m_pv = 1;
              else begin q_cmd.push_back(m_cmd); q_addr.push_back(m_addr); end
              m_seq = 0;
            end
          end
        endcase
      end else if (arr_wr && !m_err && !m_full) begin
        if (m_seq == 0) begin m_addr = arr_addr; m_seq = 1; end
        else begin m_ae = 1; m_seq = 0; end
      end
    end
    #1;
    exp_st = {(q_cmd.size() == 0), (q_cmd.size() == 0 && !m_act), m_pv, m_ae, 4'b0000};
    check("R10", "status flags", status, exp_st);
    check("R2", "div_loaded", div_loaded, m_dl);
    check("R4", "op_busy", op_busy, m_act);
    if (m_act) begin
      check("R3", "op_cmd", op_cmd, m_acmd);
      check("R3", "op_addr", op_addr, m_aaddr);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic reg_w(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic arr_w(input logic [9:0] a);
    @(negedge clk);
    arr_wr = 1'b1; arr_addr = a; arr_wdata = 16'hA5C3 ^ {6'd0, a};
    @(negedge clk);
    arr_wr = 1'b0;
  endtask

  task automatic launch_op(input logic [9:0] a, input logic [7:0] c);
    arr_w(a);
    reg_w(2'd2, c);
    reg_w(2'd3, 8'h80);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!status[6] && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(input string req, input logic [7:0] ecmd, input int elen);
    int n = 0;
    @(negedge clk);
    check(req, "op_cmd at start", op_cmd, ecmd);
    while (op_busy && n < 2000) begin n++; @(negedge clk); end
    check(req, "busy cycles", n, elen);
    check(req, "complete flag", status[6], 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- directed scenarios ----------------
  initial begin
    do_reset();
    check("R1", "status after reset", status, 8'hC0);
    check("R1", "div_loaded after reset", div_loaded, 0);
    check("R1", "op_busy after reset", op_busy, 0);

    // R7: launch before divider loaded
    launch_op(10'h010, 8'h20);
    check("R7", "launch without divider", status, 8'hD0);
    reg_w(2'd3, 8'h10);
    check("R8", "access error cleared", status, 8'hC0);

    // R2: divider load, second write ignored (visible through duration)
    reg_w(2'd0, 8'd2);
    check("R2", "divider loaded", div_loaded, 1);
    reg_w(2'd0, 8'd9);

    // R3 / R4: program timing
    launch_op(10'h005, 8'h20);
    check("R3", "buffer full after launch", status[7], 0);
    check("R3", "not yet busy", op_busy, 0);
    measure("R4", 8'h20, PROG_T * 3);

    // R4: mass erase timing
    launch_op(10'h000, 8'h41);
    measure("R4", 8'h41, ERASE_T * 3);

    // R5: buffered second command
    launch_op(10'h040, 8'h40);
    launch_op(10'h060, 8'h20);
    check("R5", "buffer full while busy", status[7], 0);
    check("R5", "complete low while held", status[6], 0);
    check("R5", "first still running", op_cmd, 8'h40);
    arr_w(10'h070);
    while (op_busy) @(negedge clk);
    check("R5", "gap cycle buffer full", status[7], 0);
    check("R5", "gap cycle complete low", status[6], 0);
    @(negedge clk);
    check("R5", "held command started", op_busy, 1);
    check("R5", "held command code", op_cmd, 8'h20);
    check("R5", "buffer free again", status[7], 1);
    wait_done();
    reg_w(2'd2, 8'h20);
    check("R5", "array write ignored when full", status, 8'hD0);
    reg_w(2'd3, 8'h10);

    // R6: protection window of two top sectors
    reg_w(2'd1, 8'd2);
    launch_op(10'h3DF, 8'h20);
    @(negedge clk);
    check("R6", "unprotected program runs", op_busy, 1);
    wait_done();
    launch_op(10'h3E0, 8'h20);
    check("R6", "protected program", status, 8'hE0);
    check("R6", "protected program not run", op_busy, 0);
    reg_w(2'd3, 8'h20);
    check("R8", "protection flag cleared", status, 8'hC0);
    launch_op(10'h000, 8'h41);
    check("R6", "mass erase with window", status, 8'hE0);
    reg_w(2'd3, 8'h20);
    launch_op(10'h3F0, 8'h40);
    check("R6", "protected sector erase", status, 8'hE0);
    reg_w(2'd3, 8'h20);
    reg_w(2'd1, 8'd0);

    // R7: access error cases
    reg_w(2'd2, 8'h20);
    check("R7", "command without address", status, 8'hD0);
    reg_w(2'd3, 8'h10);
    arr_w(10'h005); reg_w(2'd2, 8'h33);
    check("R7", "unsupported code", status, 8'hD0);
    reg_w(2'd3, 8'h10);
    arr_w(10'h005); arr_w(10'h006);
    check("R7", "double array write", status, 8'hD0);
    reg_w(2'd3, 8'h10);
    arr_w(10'h005); reg_w(2'd3, 8'h80);
    check("R7", "launch without command", status, 8'hD0);

    // R8: flags block a full valid sequence
    launch_op(10'h012, 8'h20);
    check("R8", "blocked sequence status", status, 8'hD0);
    @(negedge clk);
    check("R8", "blocked sequence not run", op_busy, 0);
    reg_w(2'd3, 8'h30);
    check("R8", "both flags cleared", status, 8'hC0);

    // R9: abort
    arr_w(10'h010); reg_w(2'd2, 8'h20); reg_w(2'd3, 8'h00);
    check("R9", "abort leaves no error", status, 8'hC0);
    reg_w(2'd3, 8'h80);
    check("R9", "launch after abort", status, 8'hD0);
    reg_w(2'd3, 8'h10);
    launch_op(10'h011, 8'h20);
    measure("R9", 8'h20, PROG_T * 3);

    // R1 / R4: second reset, divider zero
    do_reset();
    check("R1", "status after second reset", status, 8'hC0);
    check("R1", "divider cleared by reset", div_loaded, 0);
    reg_w(2'd0, 8'd0);
    launch_op(10'h100, 8'h20);
    measure("R4", 8'h20, PROG_T);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule